// File: doc/BRIEF.md
# Flash Protected Range Checker

This block decides, one request at a time, whether an access to a serial flash device may proceed. It holds five window registers. Each one describes an inclusive address window at 4 KB granularity and carries two separate enables: one that guards reads, and one that guards writes and erases. A request names a 25-bit flash byte address and whether it is a read or a write/erase. Exactly one clock later the block answers with grant or deny. Every deny also raises an error pulse.

Firmware programs the windows through a simple write port and can read them back. It then sets a lockdown bit. Windows are enforced only while locked. Until lockdown every request is granted. Once locked, the window registers and the lock itself ignore all writes until the next reset. This prevents later software from opening up protected regions.

Register word layout, which software depends on:
- Bit 31: write/erase guard enable.
- Bits 28:16: upper page number, that is, flash address bits 24:12. The window ends at that page number with the low 12 address bits all ones.
- Bit 15: read guard enable.
- Bits 12:0: lower page number. The window starts at that page number with the low 12 address bits zero.
- Bits 30:29 and 14:13: not stored, and read as zero.

Top module: `fpr_checker`

## Requirements
- R1: After reset every window word reads as zero, `locked_o` is 0, and `rsp_valid_o` and `err_o` are 0.
- R2: A write to index 0..4 before lockdown stores the word with bits 30:29 and 14:13 cleared, visible on `cfg_rdata_o` for that `cfg_ridx_i`. A write to index 5..7 changes no window, and reading index 5..7 returns zero.
- R3: A cycle with `lock_set_i` high sets `locked_o` from the next clock, and it stays high until reset.
- R4: While `locked_o` is 1, window writes are ignored: read-back and decisions are unchanged.
- R5: While unlocked, every request is granted.
- R6: `rsp_valid_o` is high in exactly the cycle after a cycle with `req_valid_i` high.
- R7: When locked, a read (`req_write_i`=0) is denied if its address lies in the inclusive window [lower*4096, upper*4096+4095] of a word with bit 15 set.
- R8: When locked, a write/erase (`req_write_i`=1) is denied under the same window rule but using bit 31. The read enable plays no part for writes, and the write enable plays no part for reads.
- R9: A window whose upper page number is below its lower page number matches no address.
- R10: `err_o` is high exactly in the response cycles whose decision is deny, with `rsp_grant_o` low.
- R11: All five windows are checked in parallel, and a hit in any one of them denies the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Window register write strobe |
| cfg_widx_i | input | 3 | Index of the window register to write |
| cfg_wdata_i | input | 32 | Word to write |
| lock_set_i | input | 1 | Sets the sticky lockdown |
| cfg_ridx_i | input | 3 | Index of the window register to read |
| cfg_rdata_o | output | 32 | Read-back of the selected window word |
| locked_o | output | 1 | Lockdown state |
| req_valid_i | input | 1 | Access request present |
| req_addr_i | input | 25 | Flash byte address |
| req_write_i | input | 1 | 1 = write/erase, 0 = read |
| rsp_valid_o | output | 1 | Decision present, one cycle after the request |
| rsp_grant_o | output | 1 | 1 = access allowed |
| err_o | output | 1 | Single-cycle pulse on each deny |

## Verification
The bench uses the default build: five windows, 25-bit addresses and 4 KB pages. This puts the top page 0x1FFF, the full-width index field with its three illegal values, and both ends of a 13-bit page compare within reach. The windows are placed so that the first and last byte of each window, and the byte just outside it, are all probed for each access kind. One window is inverted so that it matches nothing. One write carries set reserved bits. Writes are attempted after lockdown, and the bench resets again at the end.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int unsigned FPR_DW         = 32;
  localparam int unsigned FPR_ADDR_W     = 25;
  localparam int unsigned FPR_PAGE_SHIFT = 12;
  localparam int unsigned FPR_PG_W       = FPR_ADDR_W - FPR_PAGE_SHIFT;

  // field positions decoded by software
  localparam int unsigned WP_BIT = 31;
  localparam int unsigned RP_BIT = 15;
  localparam int unsigned HI_LSB = 16;
  localparam int unsigned LO_LSB = 0;

  localparam logic [FPR_DW-1:0] KEEP_MASK = 32'h9FFF_9FFF;

  typedef struct packed {
    logic                wp;
    logic                rp;
    logic [FPR_PG_W-1:0] hi;
    logic [FPR_PG_W-1:0] lo;
  } fpr_win_t;

  function automatic fpr_win_t word_to_win(logic [FPR_DW-1:0] w);
    fpr_win_t r;
    r.wp = w[WP_BIT];
    r.rp = w[RP_BIT];
    r.hi = w[HI_LSB +: FPR_PG_W];
    r.lo = w[LO_LSB +: FPR_PG_W];
    return r;
  endfunction
endpackage

// File: rtl/fpr_regs.sv
module fpr_regs
  import fpr_pkg::*;
#(
  parameter int unsigned NUM_WIN = 5,
  parameter int unsigned IDX_W   = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     widx_i,
  input  logic [FPR_DW-1:0]    wdata_i,
  input  logic                 lock_set_i,
  input  logic [IDX_W-1:0]     ridx_i,
  output logic [FPR_DW-1:0]    rdata_o,
  output logic                 locked_o,
  output fpr_win_t [NUM_WIN-1:0] win_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WIN - 1);

  logic [NUM_WIN-1:0][FPR_DW-1:0] regs_q;
  logic                           locked_q;
  logic [NUM_WIN-1:0]             wen;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    assign wen[g] = we_i && !locked_q && (widx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     regs_q[g] <= '0;
      else if (wen[g]) regs_q[g] <= wdata_i & KEEP_MASK;
    end

    assign win_o[g] = word_to_win(regs_q[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         locked_q <= 1'b0;
    else if (lock_set_i) locked_q <= 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (ridx_i == IDX_W'(i)) rdata_o = regs_q[i];
  end

  assign locked_o = locked_q;

  a_r3_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);
  a_r4_frozen_when_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(regs_q));
  a_r2_bad_index_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx_i > LAST_IDX) |=> $stable(regs_q));
endmodule

// File: rtl/fpr_win_match.sv
module fpr_win_match
  import fpr_pkg::*;
(
  input  fpr_win_t            win_i,
  input  logic [FPR_PG_W-1:0] page_i,
  input  logic                is_write_i,
  output logic                hit_o
);
  logic en;
  logic in_range;

  assign en       = is_write_i ? win_i.wp : win_i.rp;
  assign in_range = (page_i >= win_i.lo) && (page_i <= win_i.hi);
  assign hit_o    = en && in_range;

  always_comb begin
    a_r9_inverted_window_empty: assert (!(win_i.hi < win_i.lo) || !hit_o);
  end
endmodule

// File: rtl/fpr_resp.sv
module fpr_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic deny_i,
  output logic rsp_valid_o,
  output logic rsp_grant_o,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_grant_o <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_grant_o <= req_valid_i && !deny_i;
      err_o       <= req_valid_i && deny_i;
    end
  end

  a_r6_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r6_no_rsp_without_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r10_err_means_deny: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rsp_valid_o && !rsp_grant_o));
endmodule

// File: rtl/fpr_checker.sv
module fpr_checker
  import fpr_pkg::*;
#(
  parameter int unsigned NUM_WIN = 5,
  localparam int unsigned IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN + 1) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [IDX_W-1:0]      cfg_widx_i,
  input  logic [FPR_DW-1:0]     cfg_wdata_i,
  input  logic                  lock_set_i,
  input  logic [IDX_W-1:0]      cfg_ridx_i,
  output logic [FPR_DW-1:0]     cfg_rdata_o,
  output logic                  locked_o,
  input  logic                  req_valid_i,
  input  logic [FPR_ADDR_W-1:0] req_addr_i,
  input  logic                  req_write_i,
  output logic                  rsp_valid_o,
  output logic                  rsp_grant_o,
  output logic                  err_o
);
  fpr_win_t [NUM_WIN-1:0] win;
  logic [NUM_WIN-1:0]     hit;
  logic [FPR_PG_W-1:0]    page;
  logic                   deny;
  logic                   unused_low_addr;

  fpr_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i       (cfg_we_i),
    .widx_i     (cfg_widx_i),
    .wdata_i    (cfg_wdata_i),
    .lock_set_i (lock_set_i),
    .ridx_i     (cfg_ridx_i),
    .rdata_o    (cfg_rdata_o),
    .locked_o   (locked_o),
    .win_o      (win)
  );

  // page-granular compare: low address bits cannot change a decision
  assign page            = req_addr_i[FPR_ADDR_W-1:FPR_PAGE_SHIFT];
  assign unused_low_addr = ^req_addr_i[FPR_PAGE_SHIFT-1:0];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
    fpr_win_match u_match (
      .win_i      (win[g]),
      .page_i     (page),
      .is_write_i (req_write_i),
      .hit_o      (hit[g])
    );
  end

  assign deny = locked_o && (|hit);

  fpr_resp u_resp (
    .clk_i, .rst_ni,
    .req_valid_i (req_valid_i),
    .deny_i      (deny),
    .rsp_valid_o (rsp_valid_o),
    .rsp_grant_o (rsp_grant_o),
    .err_o       (err_o)
  );

  a_r5_open_before_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !locked_o) |=> rsp_grant_o);
  a_r11_any_hit_denies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && locked_o && |hit) |=> (rsp_valid_o && !rsp_grant_o));
endmodule

// File: tb/fpr_checker_tb.sv
module fpr_checker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_widx_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        lock_set_i = 1'b0;
  logic [2:0]  cfg_ridx_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        locked_o;
  logic        req_valid_i = 1'b0;
  logic [24:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic        rsp_valid_o, rsp_grant_o, err_o;

  int total = 0;
  int bad   = 0;

  always #4 clk_i = ~clk_i;

  fpr_checker u_dut (.*);

  // behavioural reference
  logic [31:0] m_reg [5];
  bit          m_lock;
  bit          e_valid, e_grant, e_err;
  string       e_tag;

  function automatic bit m_deny(logic [24:0] a, bit wr);
    bit d = 0;
    for (int i = 0; i < 5; i++) begin
      longint lo_b = longint'(m_reg[i] & 32'h1FFF) * 4096;
      longint hi_b = longint'((m_reg[i] >> 16) & 32'h1FFF) * 4096 + 4095;
      bit en = wr ? m_reg[i][31] : m_reg[i][15];
      if (en && longint'(a) >= lo_b && longint'(a) <= hi_b) d = 1;
    end
    return d && m_lock;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 5; i++) m_reg[i] = '0;
      m_lock = 0; e_valid = 0; e_grant = 0; e_err = 0; e_tag = "R1";
    end else begin
      bit d;
      d       = req_valid_i && m_deny(req_addr_i, req_write_i);
      e_valid = req_valid_i;
      e_grant = req_valid_i && !d;
      e_err   = d;
      e_tag   = !m_lock ? "R5" : (req_write_i ? "R8" : "R7");
      if (cfg_we_i && !m_lock && cfg_widx_i < 5)
        m_reg[cfg_widx_i] = cfg_wdata_i & 32'h9FFF_9FFF;
      if (lock_set_i) m_lock = 1;
    end
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk_i) begin
    #2;
    if (rst_ni) begin
      logic [31:0] er;
      er = (cfg_ridx_i < 5) ? m_reg[cfg_ridx_i] : 32'h0;
      chk(rsp_valid_o == e_valid, "R6", "rsp_valid", rsp_valid_o, e_valid);
      if (e_valid) chk(rsp_grant_o == e_grant, e_tag, "grant", rsp_grant_o, e_grant);
      chk(err_o == e_err, "R10", "err", err_o, e_err);
      chk(locked_o == m_lock, "R3", "locked", locked_o, m_lock);
      chk(cfg_rdata_o == er, m_lock ? "R4" : "R2", "rdata", cfg_rdata_o, er);
    end
  end

  task automatic wr_cfg(int idx, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_widx_i = 3'(idx); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic rd_chk(int idx, logic [31:0] exp, string tag);
    @(negedge clk_i);
    cfg_ridx_i = 3'(idx);
    #1;
    chk(cfg_rdata_o == exp, tag, "readback", cfg_rdata_o, exp);
  endtask

  task automatic do_req(logic [24:0] a, bit wr, bit exp_grant, string tag);
    @(negedge clk_i);
    req_valid_i = 1; req_addr_i = a; req_write_i = wr;
    @(posedge clk_i);
    #2;
    chk(rsp_valid_o && rsp_grant_o == exp_grant, tag, "decision", rsp_grant_o, exp_grant);
    chk(err_o == !exp_grant, "R10", "err pulse", err_o, !exp_grant);
    @(negedge clk_i);
    req_valid_i = 0;
    @(posedge clk_i);
    #2;
    chk(!err_o && !rsp_valid_o, "R10", "pulse ends", err_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!locked_o && !rsp_valid_o && !err_o, "R1", "reset outputs", {locked_o, rsp_valid_o, err_o}, 0);
    for (int i = 0; i < 5; i++) begin
      cfg_ridx_i = 3'(i); #1;
      chk(cfg_rdata_o == 0, "R1", "reset word", cfg_rdata_o, 0);
    end
    @(negedge clk_i);
    rst_ni = 1;

    wr_cfg(0, 32'h0012_8010);  // read guard, pages 0x010..0x012
    wr_cfg(1, 32'h8100_0100);  // write guard, page 0x100
    wr_cfg(2, 32'h9FFF_9FFF);  // both, top page
    wr_cfg(3, 32'h8040_8050);  // both, inverted (empty)
    wr_cfg(4, 32'hE2FF_6200);  // write guard, reserved bits set
    wr_cfg(5, 32'hFFFF_FFFF);
    wr_cfg(7, 32'hFFFF_FFFF);
    rd_chk(4, 32'h82FF_0200, "R2");
    rd_chk(0, 32'h0012_8010, "R2");
    rd_chk(5, 32'h0, "R2");
    rd_chk(7, 32'h0, "R2");

    do_req(25'h0010000, 0, 1, "R5");
    do_req(25'h0100000, 1, 1, "R5");

    @(negedge clk_i); lock_set_i = 1;
    @(negedge clk_i); lock_set_i = 0;
    chk(locked_o == 1, "R3", "lock set", locked_o, 1);

    do_req(25'h000FFFF, 0, 1, "R7");
    do_req(25'h0010000, 0, 0, "R7");
    do_req(25'h0012FFF, 0, 0, "R7");
    do_req(25'h0013000, 0, 1, "R7");
    do_req(25'h0010000, 1, 1, "R8");
    do_req(25'h0100000, 1, 0, "R8");
    do_req(25'h0100FFF, 1, 0, "R8");
    do_req(25'h0101000, 1, 1, "R8");
    do_req(25'h0100000, 0, 1, "R8");
    do_req(25'h1FFF000, 0, 0, "R11");
    do_req(25'h1FFFFFF, 1, 0, "R11");
    do_req(25'h0200000, 1, 0, "R11");
    do_req(25'h02FFFFF, 1, 0, "R11");
    do_req(25'h0045000, 0, 1, "R9");
    do_req(25'h0045000, 1, 1, "R9");
    do_req(25'h0050000, 1, 1, "R9");

    // back-to-back requests
    @(negedge clk_i); req_valid_i = 1; req_addr_i = 25'h0011000; req_write_i = 0;
    @(negedge clk_i); req_addr_i = 25'h0014000;
    @(negedge clk_i); req_addr_i = 25'h0100800; req_write_i = 1;
    @(negedge clk_i); req_valid_i = 0;

    wr_cfg(0, 32'h0);
    wr_cfg(1, 32'h0);
    @(negedge clk_i); lock_set_i = 1;
    @(negedge clk_i); lock_set_i = 0;
    rd_chk(0, 32'h0012_8010, "R4");
    rd_chk(1, 32'h8100_0100, "R4");
    do_req(25'h0010000, 0, 0, "R4");
    do_req(25'h0100000, 1, 0, "R4");
    chk(locked_o == 1, "R3", "still locked", locked_o, 1);

    @(negedge clk_i); rst_ni = 0;
    #1;
    chk(!locked_o && !rsp_valid_o && !err_o, "R1", "second reset", locked_o, 0);
    rd_chk(0, 32'h0, "R1");
    @(negedge clk_i); rst_ni = 1;
    do_req(25'h0010000, 0, 1, "R5");
    repeat (2) @(negedge clk_i);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule